// File: doc/BRIEF.md
# Dual Alarm Interrupt Controller

This block sits between two alarm comparators and the interrupt pin of a timekeeping device. Each comparator delivers a one-cycle match strobe. The block records every match in a status flag, whatever the interrupt settings are. It then decides whether the match may raise the active-low interrupt pin. That decision depends on a per-alarm enable, a recurrence mode bit and a frequency-select code. When the pin is raised, it is held as a pulse whose width is a fixed number of millisecond ticks.

The serial interface signals the end of a status read with a single-cycle strobe, which marks the eighth clock edge of that read. The strobe clears both flags. A match in the same cycle as the strobe wins over it.

In recurring mode every qualifying match gives a fresh pulse. In single-event mode an alarm pulses once. It then stays silent until software rewrites its enable from 0 to 1.

Top module: `alarm_irq_ctrl`

## Requirements
- R1: A match strobe on alarm i sets `status_o[i]` from the next cycle on. This holds whatever the enable, mode and frequency-select inputs are.
- R2: A one-cycle `rd_clr_i` strobe clears both status flags from the next cycle on.
- R3: When a match on alarm i coincides with `rd_clr_i`, `status_o[i]` remains 1. The other flag is still cleared.
- R4: A qualifying match drives `irq_n_o` low from the next cycle. A match qualifies when the alarm's enable is 1 and `freq_sel_i` is 00. The pin then stays low until exactly `PULSE_W` `ms_tick_i` cycles have been seen, and rises after the edge of the last of them.
- R5: A match arriving while a pulse is active neither extends nor restarts it. In single-event mode such a match does not use up the alarm's one event.
- R6: With `repeat_mode_i` = 1, every qualifying match that arrives while no pulse is active produces a new pulse.
- R7: With `repeat_mode_i` = 0, an alarm pulses only on its first qualifying match. Its later matches leave `irq_n_o` high until its enable input goes from 0 to 1 again.
- R8: A match on an alarm whose enable is 0 leaves `irq_n_o` high.
- R9: While `freq_sel_i` is not 00, matches leave `irq_n_o` high and do not use up a single-event alarm. A pulse in progress ends one cycle after `freq_sel_i` leaves 00.
- R10: During and right after reset, `irq_n_o` is 1 and both status flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| match_i | input | 2 | One-cycle match strobes, bit i for alarm i |
| irq_en_i | input | 2 | Per-alarm interrupt enables |
| repeat_mode_i | input | 1 | 1 = recurring pulses, 0 = single event |
| freq_sel_i | input | 2 | Frequency-select code; only 00 routes alarms to the pin |
| ms_tick_i | input | 1 | One-cycle strobe per millisecond |
| rd_clr_i | input | 1 | Status-read completion strobe from the serial interface |
| status_o | output | 2 | Alarm status flags |
| irq_n_o | output | 1 | Active-low interrupt pin, idles high |

## Verification
The pulse path is tried with a lone enabled match and with a match on a disabled alarm, which tell a real trigger from a flag-only event. It is also tried with a second match during a live pulse, which shows that the pulse neither restarts nor extends, since its end must still fall on the original tick count. Repeated matches are run under both mode settings, before and after an enable rewrite, to separate recurring behaviour from single-event behaviour and from re-arming. The flag path is tried with a plain read strobe and with a strobe that coincides with a match on one alarm only, so that match-over-clear priority is resolved per flag. A nonzero frequency code is applied both before a match and in the middle of a pulse.

// File: rtl/alarm_irq_pkg.sv
package alarm_irq_pkg;

  localparam int unsigned NUM_ALARMS = 2;
  localparam int unsigned FSEL_W     = 2;
  localparam logic [FSEL_W-1:0] FSEL_ALARM_PIN = '0;

  // True when the frequency-select code leaves the pin to the alarms.
  function automatic logic pin_routed_to_alarm(input logic [FSEL_W-1:0] code);
    return code == FSEL_ALARM_PIN;
  endfunction

  // Next status flag value: a match outranks a read-clear.
  function automatic logic flag_next(input logic cur, input logic set,
                                     input logic clr);
    if (set)      return 1'b1;
    else if (clr) return 1'b0;
    else          return cur;
  endfunction

  // Counter width able to hold values 0 .. limit-1 (at least one bit).
  function automatic int unsigned cnt_width(input int unsigned limit);
    return (limit <= 2) ? 1 : $clog2(limit);
  endfunction

endpackage

// File: rtl/alarm_slot.sv
module alarm_slot
  import alarm_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic match_i,
  input  logic en_i,
  input  logic repeat_i,
  input  logic pin_ok_i,
  input  logic busy_i,
  input  logic rd_clr_i,
  output logic flag_o,
  output logic fire_o
);

  logic flag_q;
  logic armed_q;
  logic en_q;
  logic en_rise;

  assign en_rise = en_i & ~en_q;
  assign fire_o  = match_i & en_i & (repeat_i | armed_q) & pin_ok_i & ~busy_i;
  assign flag_o  = flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b1;
      en_q    <= 1'b0;
    end else begin
      flag_q <= flag_next(flag_q, match_i, rd_clr_i);
      en_q   <= en_i;
      if (en_rise)
        armed_q <= 1'b1;
      else if (fire_o && !repeat_i)
        armed_q <= 1'b0;
    end
  end

  // R1 / R3: a match always leaves the flag set, even against a clear.
  a_r1_match_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    match_i |=> flag_o);

  // R2: a clear without a match empties the flag.
  a_r2_clear_empties_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr_i && !match_i) |=> !flag_o);

  // R7: a single-event fire cannot be followed by another fire unless re-armed.
  a_r7_single_event_spent: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_o && !repeat_i && !en_rise) |=> !armed_q);

endmodule

// File: rtl/irq_pulse_timer.sv
module irq_pulse_timer
  import alarm_irq_pkg::*;
#(
  parameter int unsigned PULSE_W = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  input  logic tick_i,
  input  logic kill_i,
  output logic active_o
);

  localparam int unsigned CW = cnt_width(PULSE_W);
  localparam logic [CW-1:0] LAST = CW'(PULSE_W - 1);

  logic          active_q;
  logic [CW-1:0] cnt_q;
  logic          last_tick;

  assign last_tick = active_q & tick_i & (cnt_q == LAST);
  assign active_o  = active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (kill_i) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (!active_q) begin
      if (trig_i) begin
        active_q <= 1'b1;
        cnt_q    <= '0;
      end
    end else if (tick_i) begin
      if (last_tick) begin
        active_q <= 1'b0;
        cnt_q    <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R4: the tick count never passes the programmed width.
  a_r4_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  // R5: with no tick, a trigger during a pulse leaves the count alone.
  a_r5_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && trig_i && !tick_i && !kill_i) |=> (active_q && $stable(cnt_q)));

  // R9: a kill request ends the pulse on the next cycle.
  a_r9_kill_ends_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    kill_i |=> !active_q);

endmodule

// File: rtl/alarm_irq_ctrl.sv
module alarm_irq_ctrl
  import alarm_irq_pkg::*;
#(
  parameter int unsigned PULSE_W = 25
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_ALARMS-1:0] match_i,
  input  logic [NUM_ALARMS-1:0] irq_en_i,
  input  logic                  repeat_mode_i,
  input  logic [FSEL_W-1:0]     freq_sel_i,
  input  logic                  ms_tick_i,
  input  logic                  rd_clr_i,
  output logic [NUM_ALARMS-1:0] status_o,
  output logic                  irq_n_o
);

  logic                  pin_ok;
  logic                  pulse_active;
  logic [NUM_ALARMS-1:0] fire_vec;
  logic                  any_fire;

  assign pin_ok   = pin_routed_to_alarm(freq_sel_i);
  assign any_fire = |fire_vec;

  for (genvar g = 0; g < NUM_ALARMS; g++) begin : g_slot
    alarm_slot i_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .match_i  (match_i[g]),
      .en_i     (irq_en_i[g]),
      .repeat_i (repeat_mode_i),
      .pin_ok_i (pin_ok),
      .busy_i   (pulse_active),
      .rd_clr_i (rd_clr_i),
      .flag_o   (status_o[g]),
      .fire_o   (fire_vec[g])
    );
  end

  irq_pulse_timer #(.PULSE_W(PULSE_W)) i_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .trig_i   (any_fire),
    .tick_i   (ms_tick_i),
    .kill_i   (~pin_ok),
    .active_o (pulse_active)
  );

  assign irq_n_o = ~pulse_active;

  // R4 / R8: the pin only falls after an enabled match with the pin routed.
  a_r4_fall_needs_enabled_match: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_n_o) |-> $past(|(match_i & irq_en_i) && pin_ok));

  // R9: with a nonzero frequency code the pin is high on the next cycle.
  a_r9_pin_released: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_ok |=> irq_n_o);

endmodule

// File: tb/test_alarm_irq_ctrl.sv
module test_alarm_irq_ctrl;

  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned PW = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] match_i = '0;
  logic [1:0] irq_en_i = '0;
  logic       repeat_mode_i = 1'b0;
  logic [1:0] freq_sel_i = '0;
  logic       ms_tick_i = 1'b0;
  logic       rd_clr_i = 1'b0;
  logic [1:0] status_o;
  logic       irq_n_o;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  alarm_irq_ctrl #(.PULSE_W(PW)) i_alarm_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .match_i(match_i), .irq_en_i(irq_en_i),
    .repeat_mode_i(repeat_mode_i), .freq_sel_i(freq_sel_i),
    .ms_tick_i(ms_tick_i), .rd_clr_i(rd_clr_i),
    .status_o(status_o), .irq_n_o(irq_n_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic strobe_match(input logic [1:0] m);
    match_i = m; cyc(); match_i = '0;
  endtask

  task automatic tick();
    ms_tick_i = 1'b1; cyc(); ms_tick_i = 1'b0; cyc();
  endtask

  task automatic read_clear();
    rd_clr_i = 1'b1; cyc(); rd_clr_i = 1'b0;
  endtask

  // Finish a live pulse: pin must stay low for PW ticks and rise after the last.
  task automatic run_out_pulse(input string req);
    for (int k = 0; k < int'(PW); k++) begin
      chk(req, {1'b0, irq_n_o}, 2'b00);
      tick();
    end
    chk(req, {1'b0, irq_n_o}, 2'b01);
  endtask

  task automatic t_reset();
    chk("R10 irq during reset", {1'b0, irq_n_o}, 2'b01);
    rst_n = 1'b1; cyc();
    chk("R10 irq after reset", {1'b0, irq_n_o}, 2'b01);
    chk("R10 flags after reset", status_o, 2'b00);
  endtask

  task automatic t_flags();
    irq_en_i = 2'b00; freq_sel_i = 2'b11;
    strobe_match(2'b10);
    chk("R1 flag set while disabled", status_o, 2'b10);
    strobe_match(2'b01);
    chk("R1 second flag", status_o, 2'b11);
    read_clear();
    chk("R2 read clears both", status_o, 2'b00);
    strobe_match(2'b11);
    match_i = 2'b01; rd_clr_i = 1'b1; cyc(); match_i = '0; rd_clr_i = 1'b0;
    chk("R3 match beats clear", status_o, 2'b01);
    read_clear();
    freq_sel_i = 2'b00;
  endtask

  task automatic t_disabled();
    irq_en_i = 2'b01;
    strobe_match(2'b10);
    chk("R8 disabled alarm no pulse", {1'b0, irq_n_o}, 2'b01);
    cyc();
    chk("R8 still idle", {1'b0, irq_n_o}, 2'b01);
    read_clear();
  endtask

  task automatic t_width_and_no_extend();
    repeat_mode_i = 1'b1; irq_en_i = 2'b01;
    strobe_match(2'b01);
    chk("R4 pulse starts", {1'b0, irq_n_o}, 2'b00);
    tick(); tick();
    strobe_match(2'b01);   // R5: must not restart the pulse
    for (int k = 2; k < int'(PW); k++) begin
      chk("R5 still low", {1'b0, irq_n_o}, 2'b00);
      tick();
    end
    chk("R5 pulse not extended", {1'b0, irq_n_o}, 2'b01);
    read_clear();
  endtask

  task automatic t_repeat();
    repeat_mode_i = 1'b1; irq_en_i = 2'b10;
    for (int r = 0; r < 3; r++) begin
      strobe_match(2'b10);
      run_out_pulse("R6 recurring pulse");
      cyc();
    end
    read_clear();
  endtask

  task automatic t_single();
    repeat_mode_i = 1'b0;
    irq_en_i = 2'b00; cyc();
    irq_en_i = 2'b01; cyc();
    strobe_match(2'b01);
    run_out_pulse("R7 first single event");
    strobe_match(2'b01);
    chk("R7 silent after first", {1'b0, irq_n_o}, 2'b01);
    irq_en_i = 2'b00; cyc();
    irq_en_i = 2'b01; cyc();
    strobe_match(2'b01);
    run_out_pulse("R7 re-armed by enable rewrite");
    read_clear();
  endtask

  task automatic t_freq();
    repeat_mode_i = 1'b0;
    irq_en_i = 2'b00; cyc(); irq_en_i = 2'b10; cyc();
    freq_sel_i = 2'b01;
    strobe_match(2'b10);
    chk("R9 nonzero code blocks pulse", {1'b0, irq_n_o}, 2'b01);
    freq_sel_i = 2'b00; cyc();
    strobe_match(2'b10);
    chk("R9 event not consumed", {1'b0, irq_n_o}, 2'b00);
    tick();
    freq_sel_i = 2'b10; cyc();
    chk("R9 pulse cut", {1'b0, irq_n_o}, 2'b01);
    freq_sel_i = 2'b00;
    read_clear();
  endtask

  initial begin
    cyc(); cyc();
    t_reset();
    t_flags();
    t_disabled();
    t_width_and_no_extend();
    t_repeat();
    t_single();
    t_freq();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule